// File: doc/BRIEF.md
# Receive Session Timeout and Restart Timer

This block watches over one receive session of a radio receiver, counting time in bit periods from a one-cycle bit tick. When receive mode is entered, three separate watchdogs start together. One waits for a signal-strength event, one for a preamble-detect event, and one for a sync-word match. If its event does not arrive within its programmed window, the watchdog raises a sticky timeout flag. Each window is an 8-bit setting multiplied by sixteen bit periods. A setting of zero switches that watchdog off.

A separate delay timer spaces out automatic receiver restarts. A restart request arms it. It then waits an 8-bit setting multiplied by four bit periods, and emits a one-cycle launch pulse on the next bit tick after that wait. Each setting is captured when its timer is armed, so later writes to the configuration pins do not change a timer that is already running.

Top module: `rxto_supervisor`

## Requirements
- R1: After reset, `timeout_flag` is 3'b000 and `restart_go` is 0.
- R2: Flag bit 0 belongs to signal strength, bit 1 to preamble and bit 2 to sync. With setting N (N>0) captured at receive entry, a flag bit rises on the clock edge that samples the 16·N-th `bit_tick` after entry, provided no event of its own has come first. The setting is sampled only in the entry cycle.
- R3: An event stops only its own watchdog. An event in the same cycle as the final tick wins, and no flag is raised.
- R4: A setting of 0 captured at entry means that flag never rises during that session.
- R5: `rx_enter` clears all three flags and restarts all three counts. A tick in the entry cycle is not counted.
- R6: Flags are sticky. A 1 on a bit of `flag_clr` clears that flag alone. A watchdog fires at most once per session. A fire and a clear in the same cycle leave the flag set.
- R7: A restart request captures delay D from `restart_gap`. `restart_go` is high for exactly one cycle, after the edge that samples the (4·D+1)-th `bit_tick` after the request. With D=0 this is the first tick.
- R8: A restart request made while a delay is pending is ignored, and the original timing stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rx_enter | input | 1 | Pulse on entry to receive mode |
| ev_rssi | input | 1 | Signal strength above threshold event |
| ev_preamble | input | 1 | Preamble detected event |
| ev_sync | input | 1 | Sync word matched event |
| flag_clr | input | 3 | Write-one-to-clear for the timeout flags |
| restart_req | input | 1 | Request an automatic receiver restart |
| lim_rssi | input | 8 | Signal strength window, units of 16 bit periods |
| lim_preamble | input | 8 | Preamble window, units of 16 bit periods |
| lim_sync | input | 8 | Sync window, units of 16 bit periods |
| restart_gap | input | 8 | Restart delay, units of 4 bit periods |
| timeout_flag | output | 3 | Sticky timeout flags (rssi, preamble, sync) |
| restart_go | output | 1 | One-cycle restart launch pulse |

## Verification
The assertions assume that reset is applied from the first clock edge. They also assume that every input is a clean, synchronous level that changes between clock edges. They do not assume that events or ticks are spaced apart. The stimulus drives all inputs on the falling edge and checks outputs there too. The random sessions put events before, on and after the final tick. They also rewrite the settings right after entry, which exercises the sampling rule in the same runs as the event and tick patterns.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
    localparam int unsigned CFG_W         = 8;
    localparam int unsigned WD_SCALE_LOG2 = 4;
    localparam int unsigned RS_SCALE_LOG2 = 2;
    localparam int unsigned NUM_WD        = 3;
    localparam int unsigned WD_CNT_W      = CFG_W + WD_SCALE_LOG2;
    localparam int unsigned RS_CNT_W      = CFG_W + RS_SCALE_LOG2;

    typedef struct packed {
        logic                armed;
        logic                flag;
        logic [CFG_W-1:0]    lim;
        logic [WD_CNT_W-1:0] cnt;
    } wd_state_t;

    typedef struct packed {
        logic                pending;
        logic                go;
        logic [RS_CNT_W-1:0] tgt;
        logic [RS_CNT_W-1:0] cnt;
    } rs_state_t;
endpackage

// File: rtl/rxto_watchdog.sv
module rxto_watchdog
    import rxto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             evt,
    input  logic             clr,
    input  logic [CFG_W-1:0] lim_in,
    output logic             flag
);
    wd_state_t d, q;
    logic [WD_CNT_W-1:0] lim_ticks;
    logic [WD_CNT_W-1:0] cnt_inc;

    assign lim_ticks = {q.lim, {WD_SCALE_LOG2{1'b0}}};
    assign cnt_inc   = q.cnt + 1'b1;

    always_comb begin
        d = q;
        if (start) begin
            d.armed = (lim_in != '0);
            d.lim   = lim_in;
            d.cnt   = '0;
            d.flag  = 1'b0;
        end else begin
            if (clr) d.flag = 1'b0;
            if (q.armed) begin
                if (evt) begin
                    d.armed = 1'b0;
                end else if (tick) begin
                    if (cnt_inc == lim_ticks) begin
                        d.flag  = 1'b1;
                        d.armed = 1'b0;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;

    // R4
    flag_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> q.lim != '0);
    // R2
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $past(tick));
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |-> q.cnt < lim_ticks);
    // R3
    event_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed && evt && !start |=> !q.armed && !$rose(q.flag));
    // R5
    entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !q.flag);
endmodule

// File: rtl/rxto_restart.sv
module rxto_restart
    import rxto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req,
    input  logic [CFG_W-1:0] gap,
    output logic             go
);
    rs_state_t d, q;

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (!q.pending) begin
            if (req) begin
                d.pending = 1'b1;
                d.tgt     = {gap, {RS_SCALE_LOG2{1'b0}}};
                d.cnt     = '0;
            end
        end else if (tick) begin
            if (q.cnt == q.tgt) begin
                d.go      = 1'b1;
                d.pending = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go = q.go;

    // R7
    go_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.go |-> $past(tick));
    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.go |=> !q.go);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pending && req |=> $stable(q.tgt));
    // R8
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pending |-> q.cnt <= q.tgt);
endmodule

// File: rtl/rxto_supervisor.sv
module rxto_supervisor
    import rxto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rx_enter,
    input  logic             ev_rssi,
    input  logic             ev_preamble,
    input  logic             ev_sync,
    input  logic [2:0]       flag_clr,
    input  logic             restart_req,
    input  logic [CFG_W-1:0] lim_rssi,
    input  logic [CFG_W-1:0] lim_preamble,
    input  logic [CFG_W-1:0] lim_sync,
    input  logic [CFG_W-1:0] restart_gap,
    output logic [2:0]       timeout_flag,
    output logic             restart_go
);
    logic [NUM_WD-1:0][CFG_W-1:0] lims;
    logic [NUM_WD-1:0]            evts;

    assign lims = {lim_sync, lim_preamble, lim_rssi};
    assign evts = {ev_sync, ev_preamble, ev_rssi};

    for (genvar i = 0; i < NUM_WD; i++) begin : g_wd
        rxto_watchdog i_wd (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (bit_tick),
            .start  (rx_enter),
            .evt    (evts[i]),
            .clr    (flag_clr[i]),
            .lim_in (lims[i]),
            .flag   (timeout_flag[i])
        );
    end

    rxto_restart i_rs (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .req   (restart_req),
        .gap   (restart_gap),
        .go    (restart_go)
    );
endmodule

// File: tb/test_rxto_supervisor.sv
module test_rxto_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0, rx_enter = 1'b0;
    logic       ev_rssi = 1'b0, ev_preamble = 1'b0, ev_sync = 1'b0;
    logic [2:0] flag_clr = '0;
    logic       restart_req = 1'b0;
    logic [7:0] lim_rssi = '0, lim_preamble = '0, lim_sync = '0, restart_gap = '0;
    logic [2:0] timeout_flag;
    logic       restart_go;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxto_supervisor i_rxto_supervisor (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_enter(rx_enter),
        .ev_rssi(ev_rssi), .ev_preamble(ev_preamble), .ev_sync(ev_sync),
        .flag_clr(flag_clr), .restart_req(restart_req),
        .lim_rssi(lim_rssi), .lim_preamble(lim_preamble), .lim_sync(lim_sync),
        .restart_gap(restart_gap), .timeout_flag(timeout_flag), .restart_go(restart_go)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_flag(input int n, input int e, input int t);
        return (n != 0) && (t >= 16 * n) && (e >= 16 * n);
    endfunction

    function automatic bit exp_go(input int d, input int k);
        return k == 4 * d + 1;
    endfunction

    task automatic drive_ev(input logic [2:0] v);
        ev_rssi = v[0]; ev_preamble = v[1]; ev_sync = v[2];
    endtask

    // One receive session: settings n*, event positions e* (after that many ticks), t ticks.
    task automatic sess(input int n0, input int n1, input int n2,
                        input int e0, input int e1, input int e2,
                        input int t, input bit same, input bit gaps, input string req);
        int n[3], e[3];
        logic [2:0] ev;
        n[0] = n0; n[1] = n1; n[2] = n2;
        e[0] = e0; e[1] = e1; e[2] = e2;
        lim_rssi = 8'(n0); lim_preamble = 8'(n1); lim_sync = 8'(n2);
        rx_enter = 1'b1;
        step();
        rx_enter = 1'b0;
        lim_rssi = 8'($urandom); lim_preamble = 8'($urandom); lim_sync = 8'($urandom);
        for (int k = 1; k <= t; k++) begin
            ev = '0;
            for (int i = 0; i < 3; i++) if (e[i] == k - 1) ev[i] = 1'b1;
            if (ev != 0 && !same) begin
                drive_ev(ev); step(); drive_ev('0);
                ev = '0;
            end
            drive_ev(ev);
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            drive_ev('0);
            for (int i = 0; i < 3; i++)
                if (n[i] != 0 && k == 16 * n[i] - 1)
                    chk({req, " flag before final tick"}, int'(timeout_flag[i]), 0);
            if (gaps && $urandom_range(0, 1) == 1) step();
        end
        for (int i = 0; i < 3; i++)
            chk({req, " flag at session end"}, int'(timeout_flag[i]), int'(exp_flag(n[i], e[i], t)));
    endtask

    task automatic rs(input int d, input bit extra, input string req);
        restart_gap = 8'(d);
        restart_req = 1'b1;
        step();
        restart_req = 1'b0;
        restart_gap = 8'($urandom);
        for (int k = 1; k <= 4 * d + 2; k++) begin
            if (extra && k <= 2) begin
                restart_req = 1'b1; restart_gap = 8'(d + 1);
                step();
                restart_req = 1'b0;
                chk({req, " idle cycle"}, int'(restart_go), 0);
            end
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            chk({req, " launch timing"}, int'(restart_go), int'(exp_go(d, k)));
            if (exp_go(d, k)) begin
                step();
                chk({req, " launch one cycle"}, int'(restart_go), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        // R1
        chk("R1 flags", int'(timeout_flag), 0);
        chk("R1 go", int'(restart_go), 0);
        rst_n = 1'b1;
        step();

        // R2 each bit alone, then max setting
        sess(1, 0, 0, 1000, 1000, 1000, 20, 0, 0, "R2 rssi");
        chk("R2 bit0 only", int'(timeout_flag), 3'b001);
        sess(0, 2, 0, 1000, 1000, 1000, 40, 0, 1, "R2 preamble");
        chk("R2 bit1 only", int'(timeout_flag), 3'b010);
        sess(0, 0, 1, 1000, 1000, 1000, 16, 0, 0, "R2 sync");
        chk("R2 bit2 only", int'(timeout_flag), 3'b100);
        sess(255, 0, 0, 1000, 1000, 1000, 4080, 0, 0, "R2 max setting");

        // R4 zero disables
        sess(0, 0, 0, 1000, 1000, 1000, 300, 0, 1, "R4 zero");
        chk("R4 no flags", int'(timeout_flag), 0);

        // R3 independence and same-cycle precedence
        sess(2, 2, 2, 5, 1000, 1000, 40, 0, 1, "R3 independent");
        chk("R3 only rssi stopped", int'(timeout_flag), 3'b110);
        sess(1, 1, 1, 15, 15, 1000, 16, 1, 0, "R3 same cycle");
        chk("R3 event wins", int'(timeout_flag), 3'b100);

        // R5 entry clears and entry tick not counted
        rx_enter = 1'b1; bit_tick = 1'b1; lim_rssi = 8'd1; lim_preamble = 8'd0; lim_sync = 8'd0;
        step();
        rx_enter = 1'b0; bit_tick = 1'b0;
        chk("R5 entry clears", int'(timeout_flag), 0);
        for (int k = 1; k <= 15; k++) begin bit_tick = 1'b1; step(); bit_tick = 1'b0; end
        chk("R5 entry tick not counted", int'(timeout_flag[0]), 0);
        bit_tick = 1'b1; step(); bit_tick = 1'b0;
        chk("R5 fire on 16th tick", int'(timeout_flag[0]), 1);

        // R6 sticky, clear one, fire once, set beats clear
        sess(1, 1, 1, 1000, 1000, 1000, 16, 0, 0, "R6 setup");
        flag_clr = 3'b010; step(); flag_clr = '0;
        chk("R6 clear one bit", int'(timeout_flag), 3'b101);
        for (int k = 0; k < 40; k++) begin bit_tick = 1'b1; step(); bit_tick = 1'b0; end
        chk("R6 fires once", int'(timeout_flag), 3'b101);
        lim_rssi = 8'd1; lim_preamble = 8'd0; lim_sync = 8'd0;
        rx_enter = 1'b1; step(); rx_enter = 1'b0;
        for (int k = 1; k <= 15; k++) begin bit_tick = 1'b1; step(); bit_tick = 1'b0; end
        bit_tick = 1'b1; flag_clr = 3'b001; step(); bit_tick = 1'b0; flag_clr = '0;
        chk("R6 set beats clear", int'(timeout_flag[0]), 1);

        // R2 R3 R4 random sessions
        for (int s = 0; s < 30; s++) begin
            int nn[3], ee[3];
            for (int i = 0; i < 3; i++) begin
                nn[i] = $urandom_range(0, 3);
                ee[i] = ($urandom_range(0, 2) == 0) ? 1000 : $urandom_range(0, 60);
            end
            sess(nn[0], nn[1], nn[2], ee[0], ee[1], ee[2], $urandom_range(0, 64),
                 1'($urandom_range(0, 1)), 1, "R2 R3 random");
        end

        // R7 restart timing
        rs(0, 0, "R7 zero delay");
        rs(1, 0, "R7 delay 1");
        rs(255, 0, "R7 max delay");
        for (int s = 0; s < 6; s++) rs($urandom_range(0, 6), 0, "R7 random");
        // R8 ignored while pending
        rs(2, 1, "R8 busy request");
        rs(0, 1, "R8 busy request zero");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule